// File: doc/BRIEF.md
# Parity-Split Physical Register File Read Stage

This block is the operand-read stage in front of a two-input execution pipe. The physical register file behind it is divided into two banks by the parity of the register number. Even-numbered registers sit only in the even bank, and odd-numbered registers sit only in the odd bank. Each bank gives the pipe a single read port. Together the two banks supply the pipe's two read ports, so each bank carries half the read ports that a single undivided file would need.

An issued micro-op arrives with up to two source tags, each with its own valid flag. The transfer uses a valid/ready handshake. The low bit of each tag picks the bank, and the remaining bits pick the row inside that bank. When the two valid sources name distinct registers of the same parity, both reads need the same port. In that case the block reads the first source, parks it in a holding register, and drops ready for one cycle. It reads the second source on the following cycle. Both operands then leave together, exactly one cycle later than an operation with no conflict. A saturating counter records every such conflict and can be cleared synchronously.

Write ports are outside this block. The bank contents come from a fixed pattern loaded at reset.

Top module: `prf_split_read`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid is 0, conflict_cnt is 0 and in_ready is 1 when no micro-op is offered. Physical register n holds the low DATA_W bits of ((n × 0x9E3779B97F4A7C15) mod 2^64) XOR 0x0123456789ABCDEF. The least significant tag bit selects the bank, with 0 for even and 1 for odd. The upper tag bits select the row.
- R2: A micro-op with two valid sources of different parity is accepted in the cycle it is offered, with in_ready = 1. Both operands appear in the cycle after acceptance.
- R3: A micro-op with two valid, distinct source tags of equal parity sees in_ready = 0 for exactly one cycle and in_ready = 1 in the next cycle. Its operands appear one cycle after that acceptance, which is one cycle later than under R2.
- R4: Two identical valid source tags are not a conflict. The micro-op is accepted without a stall, and both operands carry the same register value.
- R5: A micro-op with at most one valid source is accepted without a stall. An operand whose source is not valid is returned as zero.
- R6: out_valid is 1 for exactly one cycle, the cycle after each acceptance (in_valid and in_ready both 1). It is 0 in every other cycle, including the stall cycle of a conflict.
- R7: conflict_cnt rises by one for each conflicting micro-op, in the cycle after the stall begins. It saturates at 2^CNT_W − 1.
- R8: cnt_clr forces conflict_cnt to zero on the next clock edge. This takes precedence over an increment on the same edge.
- R9: While in_valid is 1 and in_ready is 0, the upstream stage keeps in_valid and both source tags unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A micro-op is offered |
| in_ready | output | 1 | The stage takes the offered micro-op this cycle |
| in_src0_tag | input | $clog2(NUM_REGS) | First source physical register number |
| in_src0_vld | input | 1 | First source is used |
| in_src1_tag | input | $clog2(NUM_REGS) | Second source physical register number |
| in_src1_vld | input | 1 | Second source is used |
| cnt_clr | input | 1 | Synchronous clear of the conflict counter |
| out_valid | output | 1 | Operands are presented this cycle |
| out_op0 | output | DATA_W | First operand value |
| out_op1 | output | DATA_W | Second operand value |
| conflict_cnt | output | CNT_W | Saturating count of bank conflicts |

## Verification
A micro-op offered without a conflict is accepted on the first rising edge, and its operands and out_valid are due one cycle after that edge. A conflicting micro-op shows in_ready low in its first cycle and high in its second. Its operands and the incremented counter are due one edge after the second cycle. Each scenario task first waits for an idle edge, then drives its inputs on the falling edge. It samples in_ready one nanosecond after that drive, and samples out_valid, the operands and the counter one nanosecond after the edge on which they are due. It also confirms that out_valid is low during the stall and again one cycle after the result.

// File: rtl/prf_pkg.sv
package prf_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } prf_phase_e;

    // Reset pattern of physical register idx (low bits are taken by the user)
    function automatic logic [63:0] prf_reset_word(input int unsigned idx);
        logic [63:0] prod;
        prod = 64'(idx) * 64'h9E37_79B9_7F4A_7C15;
        return prod ^ 64'h0123_4567_89AB_CDEF;
    endfunction

endpackage

// File: rtl/prf_bank.sv
module prf_bank #(
    parameter int ROWS    = 32,
    parameter int DATA_W  = 32,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);
    import prf_pkg::*;

    logic [DATA_W-1:0] mem_d [ROWS];
    logic [DATA_W-1:0] mem_q [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            mem_d[r] = mem_q[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= DATA_W'(prf_reset_word(2 * r + BANK_ID));
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= mem_d[r];
            end
        end
    end

    assign rd_data = mem_q[rd_row];

endmodule

// File: rtl/prf_steer.sv
module prf_steer #(
    parameter int TAG_W  = 6,
    localparam int ROW_W = TAG_W - 1
) (
    input  logic [TAG_W-1:0] tag0,
    input  logic             vld0,
    input  logic [TAG_W-1:0] tag1,
    input  logic             vld1,
    input  logic             second_phase,
    output logic             conflict,
    output logic [ROW_W-1:0] row_even,
    output logic [ROW_W-1:0] row_odd
);
    logic [ROW_W-1:0] r0;
    logic [ROW_W-1:0] r1;

    assign r0 = tag0[TAG_W-1:1];
    assign r1 = tag1[TAG_W-1:1];

    always_comb begin
        conflict = vld0 && vld1 && (tag0[0] == tag1[0]) && (tag0 != tag1);
        if (second_phase) begin
            // only the conflicting bank is consumed; it serves source 1
            row_even = r1;
            row_odd  = r1;
        end else begin
            row_even = (vld0 && !tag0[0]) ? r0 : r1;
            row_odd  = (vld0 &&  tag0[0]) ? r0 : r1;
        end
    end

endmodule

// File: rtl/prf_split_read.sv
module prf_split_read #(
    parameter int NUM_REGS = 64,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [$clog2(NUM_REGS)-1:0] in_src0_tag,
    input  logic                        in_src0_vld,
    input  logic [$clog2(NUM_REGS)-1:0] in_src1_tag,
    input  logic                        in_src1_vld,
    input  logic                        cnt_clr,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_op0,
    output logic [DATA_W-1:0]           out_op1,
    output logic [CNT_W-1:0]            conflict_cnt
);
    import prf_pkg::*;

    localparam int TAG_W = $clog2(NUM_REGS);
    localparam int ROW_W = TAG_W - 1;
    localparam int ROWS  = NUM_REGS / 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        prf_phase_e        phase;
        logic [DATA_W-1:0] hold;
        logic              out_vld;
        logic [DATA_W-1:0] op0;
        logic [DATA_W-1:0] op1;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic             conflict;
    logic [ROW_W-1:0] bank_row  [2];
    logic [DATA_W-1:0] bank_data [2];

    prf_steer #(.TAG_W(TAG_W)) u_steer (
        .tag0         (in_src0_tag),
        .vld0         (in_src0_vld),
        .tag1         (in_src1_tag),
        .vld1         (in_src1_vld),
        .second_phase (st_q.phase == PH_SECOND),
        .conflict     (conflict),
        .row_even     (bank_row[0]),
        .row_odd      (bank_row[1])
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        prf_bank #(.ROWS(ROWS), .DATA_W(DATA_W), .BANK_ID(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_row  (bank_row[b]),
            .rd_data (bank_data[b])
        );
    end

    logic [DATA_W-1:0] port0_val;
    logic [DATA_W-1:0] port1_val;
    logic              accept;

    always_comb begin
        port0_val = bank_data[in_src0_tag[0]];
        port1_val = bank_data[in_src1_tag[0]];
        in_ready  = (st_q.phase == PH_SECOND) || !conflict;
        accept    = in_valid && in_ready;

        st_d         = st_q;
        st_d.out_vld = accept;
        if (accept) begin
            st_d.op0   = (st_q.phase == PH_SECOND) ? st_q.hold
                       : (in_src0_vld ? port0_val : '0);
            st_d.op1   = in_src1_vld ? port1_val : '0;
            st_d.phase = PH_FIRST;
        end else if (in_valid && conflict) begin
            st_d.hold  = port0_val;
            st_d.phase = PH_SECOND;
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.phase = PH_FIRST;
        end
        if (cnt_clr) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.out_vld;
    assign out_op0      = st_q.op0;
    assign out_op1      = st_q.op1;
    assign conflict_cnt = st_q.cnt;

    // R3
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> in_ready);

    // R6
    out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R6
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_cnt == CNT_MAX && !cnt_clr) |=> conflict_cnt == CNT_MAX);

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> conflict_cnt == '0);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (in_valid && $stable(in_src0_tag) && $stable(in_src1_tag)));

endmodule

// File: tb/prf_split_read_tb.sv
module prf_split_read_tb;

    localparam int NUM_REGS = 64;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 8;
    localparam int TAG_W    = $clog2(NUM_REGS);
    localparam int CNT_TOP  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TAG_W-1:0]  in_src0_tag = '0;
    logic              in_src0_vld = 1'b0;
    logic [TAG_W-1:0]  in_src1_tag = '0;
    logic              in_src1_vld = 1'b0;
    logic              cnt_clr = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_op0;
    logic [DATA_W-1:0] out_op1;
    logic [CNT_W-1:0]  conflict_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    prf_split_read #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_src0_tag  (in_src0_tag),
        .in_src0_vld  (in_src0_vld),
        .in_src1_tag  (in_src1_tag),
        .in_src1_vld  (in_src1_vld),
        .cnt_clr      (cnt_clr),
        .out_valid    (out_valid),
        .out_op0      (out_op0),
        .out_op1      (out_op1),
        .conflict_cnt (conflict_cnt)
    );

    function automatic logic [63:0] exp_word(input int n, input bit v);
        logic [63:0] p;
        if (!v) return 64'd0;
        p = (64'(n) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
        return {32'd0, p[31:0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input int t0, input bit v0, input int t1, input bit v1,
                         input bit stall, input string req);
        @(posedge clk);
        @(negedge clk);
        in_src0_tag = TAG_W'(t0);
        in_src0_vld = v0;
        in_src1_tag = TAG_W'(t1);
        in_src1_vld = v1;
        in_valid    = 1'b1;
        #1;
        chk(req, "in_ready first cycle", 64'(in_ready), 64'(!stall));
        if (stall) begin
            chk(req, "out_valid in stall", 64'(out_valid), 64'd0);
            if (exp_cnt < CNT_TOP) exp_cnt++;
            @(negedge clk);
            #1;
            chk(req, "in_ready second cycle", 64'(in_ready), 64'd1);
            chk("R7", "count after conflict", 64'(conflict_cnt), 64'(exp_cnt));
        end
        @(posedge clk);
        #1;
        in_valid    = 1'b0;
        in_src0_vld = 1'b0;
        in_src1_vld = 1'b0;
        chk(req, "out_valid", 64'(out_valid), 64'd1);
        chk(req, "op0", 64'(out_op0), exp_word(t0, v0));
        chk(req, "op1", 64'(out_op1), exp_word(t1, v1));
        @(posedge clk);
        #1;
        chk("R6", "out_valid one cycle only", 64'(out_valid), 64'd0);
        chk("R7", "count", 64'(conflict_cnt), 64'(exp_cnt));
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1", "count in reset", 64'(conflict_cnt), 64'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "in_ready idle", 64'(in_ready), 64'd1);
        chk("R1", "out_valid idle", 64'(out_valid), 64'd0);
    endtask

    task automatic t_split;
        issue(4, 1, 9, 1, 1'b0, "R2");
        issue(33, 1, 62, 1, 1'b0, "R2");
        issue(0, 1, 63, 1, 1'b0, "R1");
    endtask

    task automatic t_conflict;
        issue(2, 1, 10, 1, 1'b1, "R3");
        issue(61, 1, 7, 1, 1'b1, "R3");
    endtask

    task automatic t_same_tag;
        issue(18, 1, 18, 1, 1'b0, "R4");
        issue(45, 1, 45, 1, 1'b0, "R4");
    endtask

    task automatic t_single;
        issue(12, 1, 20, 0, 1'b0, "R5");
        issue(3, 0, 11, 1, 1'b0, "R5");
        issue(5, 0, 7, 0, 1'b0, "R5");
    endtask

    task automatic t_clear;
        @(posedge clk);
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_cnt = 0;
        #1;
        chk("R8", "count after clear", 64'(conflict_cnt), 64'd0);
        // clear on the same edge as a conflict increment
        @(negedge clk);
        in_src0_tag = TAG_W'(6);
        in_src0_vld = 1'b1;
        in_src1_tag = TAG_W'(14);
        in_src1_vld = 1'b1;
        in_valid    = 1'b1;
        cnt_clr     = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        #1;
        chk("R8", "clear beats increment", 64'(conflict_cnt), 64'd0);
        @(posedge clk);
        #1;
        in_valid    = 1'b0;
        in_src0_vld = 1'b0;
        in_src1_vld = 1'b0;
        chk("R3", "op0 after cleared conflict", 64'(out_op0), exp_word(6, 1));
        chk("R3", "op1 after cleared conflict", 64'(out_op1), exp_word(14, 1));
    endtask

    task automatic t_saturate;
        for (int i = 0; i < CNT_TOP + 3; i++) begin
            issue((2 * i + 1) % NUM_REGS, 1, (2 * i + 3) % NUM_REGS, 1, 1'b1, "R7");
        end
        chk("R7", "saturated count", 64'(conflict_cnt), 64'(CNT_TOP));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_split();
        t_conflict();
        t_same_tag();
        t_single();
        t_clear();
        t_saturate();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule